// File: doc/BRIEF.md
# Switching-Synchronous Current Averaging Filter

This block turns a stream of inductor-current conversions into one mean value per switching period. A period-start strobe marks the beginning of each switching cycle. Within that cycle a fixed number of conversions, evenly spaced and locked to the switching clock, arrive on a strobe with a valid qualifier. The block sums them and publishes their mean as soon as the last one of the period has arrived. That is just ahead of the next switching pulse, so the downstream compensator has fresh data almost at once.

Because the window is a whole switching period, the filter is a block (boxcar) average rather than a running one. Each output reflects only one period's samples. Ripple at the switching frequency and its harmonics averages out, and the group delay is half a period. A period that closes before all of its samples have arrived yields no new value. The last good mean is held and a fault flag is raised until a complete period succeeds again.

Top module: `cur_avg_filter`

## Requirements
- R1: After asynchronous reset (rst_ni low), avg_o is 0, avg_vld_o is 0 and short_err_o is 0.
- R2: avg_vld_o is high for exactly one clock: the cycle after the clock edge that captured the 16th accepted sample of a period. It is low in every other cycle.
- R3: avg_o is loaded at the same moment as the avg_vld_o pulse with floor(sum of the period's 16 accepted samples / 16). Between pulses it holds its value.
- R4: Sixteen full-scale samples (1023) give avg_o = 1023, with no wraparound in the 14-bit running sum.
- R5: A sample is accepted only in a cycle where sample_stb_i and sample_vld_i are both 1. Other cycles neither count toward the 16 nor add to the sum.
- R6: When period_start_i closes a period that accepted fewer than 16 samples (including zero), short_err_o goes to 1 on the next cycle. avg_o keeps its previous value. short_err_o stays 1 until the next avg_vld_o pulse and clears together with it.
- R7: Samples accepted after the 16th in the same period are ignored. They change neither avg_o nor avg_vld_o, and the period start that closes that full period raises no error.
- R8: A sample accepted in the same cycle as period_start_i counts as the first sample of the new period.
- R9: Until the first period_start_i after reset, all samples are ignored. That first period start raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| period_start_i | input | 1 | One-cycle strobe at the start of each switching period |
| sample_stb_i | input | 1 | Sampling instant strobe |
| sample_vld_i | input | 1 | Conversion word is valid |
| sample_i | input | 10 | Unsigned current conversion word |
| avg_o | output | 10 | Mean current of the last complete period |
| avg_vld_o | output | 1 | One-cycle pulse when avg_o is updated |
| short_err_o | output | 1 | Last period closed with too few samples |

## Verification
All three outputs are registered, and each is due exactly one clock after the rising edge that sees its cause. For avg_o and avg_vld_o the cause is the 16th accepted sample. For short_err_o it is the closing period start. The bench changes inputs only on the falling edge and updates its behavioural model on the rising edge. It then compares every output against the model at the next falling edge, so each result is checked in the very cycle it is due. Directed checks taken at the end of each scenario add fixed expected values for rounding, full scale, ignored samples and faults.

// File: rtl/cur_avg_pkg.sv
package cur_avg_pkg;
  localparam int unsigned DEF_SMP_W = 10;
  localparam int unsigned DEF_N     = 16;

  function automatic int unsigned sum_width(input int unsigned smp_w, input int unsigned n);
    return smp_w + $clog2(n);
  endfunction
endpackage

// File: rtl/cur_avg_ctr.sv
module cur_avg_ctr #(
  parameter int unsigned N     = 16,
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             period_start_i,
  input  logic             sample_stb_i,
  input  logic             sample_vld_i,
  output logic             take_o,
  output logic             last_o,
  output logic             short_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic             open_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_base;
  logic             open_eff;

  // a period start restarts the count in the same cycle
  always_comb begin
    cnt_base = period_start_i ? '0 : cnt_q;
    open_eff = open_q | period_start_i;
    take_o   = sample_stb_i & sample_vld_i & open_eff & (cnt_base < CNT_W'(N));
    last_o   = take_o & (cnt_base == CNT_W'(N - 1));
    short_o  = period_start_i & open_q & (cnt_q != CNT_W'(N));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      open_q <= open_eff;
      cnt_q  <= cnt_base + CNT_W'(take_o);
    end
  end

  assign cnt_o = cnt_q;

  a_r7_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(N));

  a_r9_idle_before_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !open_q |-> cnt_q == '0);

  a_r8_same_cycle_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_start_i && sample_stb_i && sample_vld_i) |=> cnt_q == CNT_W'(1));
endmodule

// File: rtl/cur_avg_accum.sv
module cur_avg_accum #(
  parameter int unsigned SMP_W = 10,
  parameter int unsigned ACC_W = 14,
  parameter int unsigned CNT_W = 5,
  parameter int unsigned SHIFT = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             period_start_i,
  input  logic             take_i,
  input  logic [SMP_W-1:0] sample_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [SMP_W-1:0] mean_o
);
  localparam int unsigned SMP_MAX = (1 << SMP_W) - 1;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_base;
  logic [ACC_W-1:0] sum;

  always_comb begin
    acc_base = period_start_i ? '0 : acc_q;
    sum      = acc_base + ACC_W'(sample_i);
    mean_o   = SMP_W'(sum >> SHIFT);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (take_i) acc_q <= sum;
    else            acc_q <= acc_base;
  end

  // running sum never exceeds count * full scale
  a_r4_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(acc_q) <= 32'(cnt_i) * SMP_MAX);
endmodule

// File: rtl/cur_avg_out.sv
module cur_avg_out #(
  parameter int unsigned SMP_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             period_start_i,
  input  logic             last_i,
  input  logic             short_i,
  input  logic [SMP_W-1:0] mean_i,
  output logic [SMP_W-1:0] avg_o,
  output logic             avg_vld_o,
  output logic             short_err_o
);
  logic [SMP_W-1:0] avg_q;
  logic             vld_q;
  logic             err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      avg_q <= '0;
      vld_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      vld_q <= last_i;
      if (last_i) avg_q <= mean_i;
      if (short_i)     err_q <= 1'b1;
      else if (last_i) err_q <= 1'b0;
    end
  end

  assign avg_o       = avg_q;
  assign avg_vld_o   = vld_q;
  assign short_err_o = err_q;

  a_r2_vld_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    avg_vld_o |=> !avg_vld_o);

  a_r3_hold_between: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !avg_vld_o |-> $stable(avg_o));

  a_r6_err_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(short_err_o) |-> $past(period_start_i));

  a_r6_err_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(short_err_o) |-> avg_vld_o);
endmodule

// File: rtl/cur_avg_filter.sv
module cur_avg_filter
  import cur_avg_pkg::*;
#(
  parameter int unsigned SMP_W = DEF_SMP_W,
  parameter int unsigned N     = DEF_N
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             period_start_i,
  input  logic             sample_stb_i,
  input  logic             sample_vld_i,
  input  logic [SMP_W-1:0] sample_i,
  output logic [SMP_W-1:0] avg_o,
  output logic             avg_vld_o,
  output logic             short_err_o
);
  localparam int unsigned LOG2N = $clog2(N);
  localparam int unsigned CNT_W = LOG2N + 1;
  localparam int unsigned ACC_W = sum_width(SMP_W, N);

  if ((1 << LOG2N) != N || N < 2) begin : g_bad_n
    $error("N must be a power of two of at least 2");
  end

  logic             take;
  logic             last;
  logic             short_close;
  logic [CNT_W-1:0] cnt;
  logic [SMP_W-1:0] mean;

  cur_avg_ctr #(.N(N), .CNT_W(CNT_W)) u_ctr (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .period_start_i (period_start_i),
    .sample_stb_i   (sample_stb_i),
    .sample_vld_i   (sample_vld_i),
    .take_o         (take),
    .last_o         (last),
    .short_o        (short_close),
    .cnt_o          (cnt)
  );

  cur_avg_accum #(.SMP_W(SMP_W), .ACC_W(ACC_W), .CNT_W(CNT_W), .SHIFT(LOG2N)) u_acc (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .period_start_i (period_start_i),
    .take_i         (take),
    .sample_i       (sample_i),
    .cnt_i          (cnt),
    .mean_o         (mean)
  );

  cur_avg_out #(.SMP_W(SMP_W)) u_out (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .period_start_i (period_start_i),
    .last_i         (last),
    .short_i        (short_close),
    .mean_i         (mean),
    .avg_o          (avg_o),
    .avg_vld_o      (avg_vld_o),
    .short_err_o    (short_err_o)
  );
endmodule

// File: tb/cur_avg_filter_bench.sv
module cur_avg_filter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N          = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ps = 1'b0, stb = 1'b0, vld = 1'b0;
  logic [9:0] smp = '0;
  logic [9:0] avg;
  logic       avg_vld, err;

  int n_chk = 0, n_fail = 0, vld_cnt = 0;

  cur_avg_filter u_cur_avg_filter (
    .clk_i(clk), .rst_ni(rst_n), .period_start_i(ps), .sample_stb_i(stb),
    .sample_vld_i(vld), .sample_i(smp), .avg_o(avg), .avg_vld_o(avg_vld),
    .short_err_o(err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference
  int q[$];
  bit m_open;
  int m_avg;
  bit m_vld, m_err;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete(); m_open = 0; m_avg = 0; m_vld = 0; m_err = 0;
    end else begin
      m_vld = 0;
      if (ps) begin
        if (m_open && q.size() != N) m_err = 1;
        q.delete();
        m_open = 1;
      end
      if (stb && vld && m_open && q.size() < N) begin
        q.push_back(int'(smp));
        if (q.size() == N) begin
          int s;
          s = 0;
          foreach (q[i]) s += q[i];
          m_avg = s / N; m_vld = 1; m_err = 0;
        end
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(bit p, bit s, bit v, int d);
    @(negedge clk);
    if (rst_n) begin
      chk("R3 avg_o vs model", int'(avg), m_avg);
      chk("R2 avg_vld_o vs model", int'(avg_vld), int'(m_vld));
      chk("R6 short_err_o vs model", int'(err), int'(m_err));
      if (avg_vld) vld_cnt++;
    end
    ps = p; stb = s; vld = v; smp = 10'(d);
  endtask

  task automatic feed(int d);
    step(0, 1, 1, d);
    step(0, 0, 0, 0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    int vb;
    repeat (3) @(negedge clk);
    chk("R1 reset avg_o", int'(avg), 0);
    chk("R1 reset avg_vld_o", int'(avg_vld), 0);
    chk("R1 reset short_err_o", int'(err), 0);
    rst_n = 1'b1;

    // R9: samples before any period start are ignored
    for (int i = 0; i < N; i++) feed(777);
    chk("R9 no pulse before first start", vld_cnt, 0);
    chk("R9 avg untouched", int'(avg), 0);
    step(1, 0, 0, 0);
    step(0, 0, 0, 0);
    chk("R9 first start no error", int'(err), 0);

    // R8: sample together with period start is the first one
    step(1, 1, 1, 100);
    step(0, 0, 0, 0);
    for (int i = 1; i < N; i++) feed(100);
    chk("R8 same-cycle sample counted", int'(avg), 100);
    chk("R2 pulse after 16th sample", int'(avg_vld), 1);

    // R3: truncating ramp, sum 8088 -> 505
    step(1, 0, 0, 0);
    for (int i = 0; i < N; i++) feed(i * 67 + 3);
    chk("R3 ramp mean truncated", int'(avg), 505);

    // R4: full scale
    step(1, 0, 0, 0);
    for (int i = 0; i < N; i++) feed(1023);
    chk("R4 full scale mean", int'(avg), 1023);

    // R5: unqualified cycles ignored
    step(1, 0, 0, 0);
    vb = vld_cnt;
    for (int i = 0; i < N; i++) begin
      step(0, 1, 0, 1000);
      step(0, 0, 1, 999);
      feed(200);
    end
    chk("R5 invalid samples not counted", int'(avg), 200);
    chk("R5 single pulse per period", vld_cnt - vb, 1);

    // R7: extras beyond 16 ignored
    step(1, 0, 0, 0);
    for (int i = 0; i < N; i++) feed(300);
    chk("R7 full period mean", int'(avg), 300);
    vb = vld_cnt;
    for (int i = 0; i < 4; i++) feed(900);
    chk("R7 extras leave avg", int'(avg), 300);
    chk("R7 extras give no pulse", vld_cnt - vb, 0);
    step(1, 0, 0, 0);
    step(0, 0, 0, 0);
    chk("R7 full period no error", int'(err), 0);

    // R6: short period, hold, then recovery
    for (int i = 0; i < 10; i++) feed(700);
    step(1, 0, 0, 0);
    step(0, 0, 0, 0);
    chk("R6 short period flags", int'(err), 1);
    chk("R6 short period holds avg", int'(avg), 300);
    for (int i = 0; i < N - 1; i++) feed(50);
    chk("R6 error held until pulse", int'(err), 1);
    feed(50);
    chk("R6 error cleared with pulse", int'(err), 0);
    chk("R6 recovered mean", int'(avg), 50);

    // R6: empty period
    step(1, 0, 0, 0);
    step(1, 0, 0, 0);
    step(0, 0, 0, 0);
    chk("R6 empty period flags", int'(err), 1);

    // R1: reset in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 mid reset avg_o", int'(avg), 0);
    chk("R1 mid reset short_err_o", int'(err), 0);
    @(negedge clk);
    rst_n = 1'b1;
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);

    finish_run();
  end
endmodule